// File: doc/BRIEF.md
# Grouped Implication Checker Array

This block watches a vector of internal circuit sites for breaks in invariant relationships. Each relationship, or implication, has the form "site A at value a forces site B to value b". A small detector flags the one combination of values that such a relationship forbids. The detectors are split into groups. Each group ORs its members into one error signal, and a sticky flag captures that signal. The flags together form a failure signature. The signature shows which group of relationships broke, so it narrows the list of suspect faults for later targeted testing. A single error output also summarises the signature.

An implication only holds once the monitored logic has settled, so capture has two gates. The first is an explicit sample enable. The second is an internal stability filter: a violation counts only after the site vector has stayed unchanged for a set number of cycles. Software-free clearing is done through a clear input, and clear wins over a violation in the same cycle. Parameters fix which implications are monitored and how they are grouped. A function in the package computes both, so no table has to be stored.

Top module: `ica_checker_array`

## Requirements
- R1: Implication k is violated exactly when its antecedent site equals its antecedent value and its consequent site differs from its consequent value.
- R2: Implication k (0 ≤ k < N_IMPL) has antecedent site k mod N_SITES with antecedent value bit 0 of k. Its consequent site is (5k+3) mod N_SITES with consequent value bit 1 of k. It belongs to group k mod N_GROUPS, and signature bit g is group g.
- R3: At a qualified capture edge, signature bit g is set when at least one violated implication belongs to group g. A group with no violated member keeps its bit unchanged.
- R4: A set signature bit stays set while clear is low, whatever the site values are.
- R5: While sample enable is low, the signature does not change except through clear.
- R6: A violation is captured only once the site vector has been equal at SETTLE_CYC consecutive clock edges and is still equal to its last sampled value. With sample enable high, a violating vector applied before an edge is captured at the (SETTLE_CYC+2)-th edge, and no earlier.
- R7: Clear, sampled at a clock edge, zeroes the whole signature. It takes priority over a qualified violation at the same edge.
- R8: The global error output equals the OR of all signature bits in every cycle.
- R9: Synchronous active-high reset zeroes the signature and the global error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sites_i | input | N_SITES | Monitored circuit site values |
| sample_en_i | input | 1 | Permits capture of group errors |
| clear_i | input | 1 | Zeroes the signature; wins over capture |
| signature_o | output | N_GROUPS | Sticky per-group failure flags |
| any_err_o | output | 1 | OR of all signature bits |

## Verification
The hardest condition to reach from the ports is a site vector that breaks implications in exactly one group and in no other. The implications share sites, so most vectors trip several groups at once. Before the tests run, the bench searches the whole site space with its own model of the rule table and picks, for each group, a vector whose predicted violations fall only in that group. It also finds a vector with no violations at all. These vectors drive the isolation, settling and clear-priority scenarios. The settling case then places the quiet-to-violating switch exactly SETTLE_CYC+1 edges ahead of a check, so the check falls just before the capture edge, and it also alternates the two vectors on every cycle.

// File: rtl/ica_pkg.sv
package ica_pkg;

    // One monitored relationship: ante site at ante_val forces cons site to cons_val
    typedef struct packed {
        int unsigned ante;
        logic        ante_val;
        int unsigned cons;
        logic        cons_val;
        int unsigned grp;
    } impl_rule_t;

    // Capture command seen by the signature register
    typedef struct packed {
        logic clr;
        logic cap;
    } cap_cmd_t;

    // Computed rule table: no stored table needed
    function automatic impl_rule_t rule_of(input int unsigned k,
                                           input int unsigned n_sites,
                                           input int unsigned n_groups);
        impl_rule_t r;
        r.ante     = k % n_sites;
        r.ante_val = k[0];
        r.cons     = (5 * k + 3) % n_sites;
        r.cons_val = k[1];
        r.grp      = k % n_groups;
        return r;
    endfunction

endpackage

// File: rtl/ica_settle.sv
module ica_settle #(
    parameter int N_SITES    = 16,
    parameter int SETTLE_CYC = 2
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [N_SITES-1:0] sites_i,
    output logic               settled_o
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(SETTLE_CYC);

    logic [N_SITES-1:0] sites_q;
    logic [CW-1:0]      stable_cnt;
    logic               same;

    assign same = (sites_i == sites_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sites_q    <= '0;
            stable_cnt <= '0;
        end else begin
            sites_q <= sites_i;
            if (!same)
                stable_cnt <= '0;
            else if (stable_cnt != CNT_MAX)
                stable_cnt <= stable_cnt + 1'b1;
        end
    end

    assign settled_o = same && (stable_cnt == CNT_MAX);

    AST_SETTLED_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        settled_o |-> $stable(sites_i)); // R6

endmodule

// File: rtl/ica_detector.sv
module ica_detector #(
    parameter logic ANTE_VAL = 1'b1,
    parameter logic CONS_VAL = 1'b0
) (
    input  logic ante_bit_i,
    input  logic cons_bit_i,
    output logic viol_o
);
    // Fires only on the forbidden combination
    assign viol_o = (ante_bit_i == ANTE_VAL) && (cons_bit_i != CONS_VAL);
endmodule

// File: rtl/ica_group_or.sv
module ica_group_or #(
    parameter int N_SITES  = 16,
    parameter int N_IMPL   = 16,
    parameter int N_GROUPS = 4
) (
    input  logic [N_IMPL-1:0]   viol_i,
    output logic [N_GROUPS-1:0] grp_err_o
);
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic [N_IMPL-1:0] member;
        for (genvar k = 0; k < N_IMPL; k++) begin : g_mem
            localparam ica_pkg::impl_rule_t RULE = ica_pkg::rule_of(k, N_SITES, N_GROUPS);
            if (RULE.grp == g) begin : g_in
                assign member[k] = 1'b1;
            end else begin : g_out
                assign member[k] = 1'b0;
            end
        end
        assign grp_err_o[g] = |(viol_i & member);
    end
endmodule

// File: rtl/ica_sig_reg.sv
module ica_sig_reg #(
    parameter int N_GROUPS = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  ica_pkg::cap_cmd_t     cmd_i,
    input  logic [N_GROUPS-1:0]   grp_err_i,
    output logic [N_GROUPS-1:0]   flags_o
);
    logic [N_GROUPS-1:0] flags_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            flags_q <= '0;
        else if (cmd_i.clr)
            flags_q <= '0;
        else if (cmd_i.cap)
            flags_q <= flags_q | grp_err_i;
    end

    assign flags_o = flags_q;

    AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_i.clr |=> (flags_q == '0)); // R7

    AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        !cmd_i.clr |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R4

    AST_HOLD_NO_SAMPLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cmd_i.clr && !cmd_i.cap) |=> $stable(flags_q)); // R5

endmodule

// File: rtl/ica_checker_array.sv
module ica_checker_array #(
    parameter int N_SITES    = 16,
    parameter int N_IMPL     = 16,
    parameter int N_GROUPS   = 4,
    parameter int SETTLE_CYC = 2
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [N_SITES-1:0]  sites_i,
    input  logic                sample_en_i,
    input  logic                clear_i,
    output logic [N_GROUPS-1:0] signature_o,
    output logic                any_err_o
);
    localparam int SW = (N_SITES > 1) ? $clog2(N_SITES) : 1;

    logic [N_IMPL-1:0]   viol;
    logic [N_GROUPS-1:0] grp_err;
    logic                settled;
    ica_pkg::cap_cmd_t   cmd;

    ica_settle #(.N_SITES(N_SITES), .SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sites_i   (sites_i),
        .settled_o (settled)
    );

    for (genvar k = 0; k < N_IMPL; k++) begin : g_impl
        localparam ica_pkg::impl_rule_t RULE = ica_pkg::rule_of(k, N_SITES, N_GROUPS);
        localparam logic [SW-1:0] A_IDX = SW'(RULE.ante);
        localparam logic [SW-1:0] C_IDX = SW'(RULE.cons);
        ica_detector #(.ANTE_VAL(RULE.ante_val), .CONS_VAL(RULE.cons_val)) u_det (
            .ante_bit_i (sites_i[A_IDX]),
            .cons_bit_i (sites_i[C_IDX]),
            .viol_o     (viol[k])
        );
    end

    ica_group_or #(.N_SITES(N_SITES), .N_IMPL(N_IMPL), .N_GROUPS(N_GROUPS)) u_or (
        .viol_i    (viol),
        .grp_err_o (grp_err)
    );

    assign cmd.clr = clear_i;
    assign cmd.cap = sample_en_i && settled;

    ica_sig_reg #(.N_GROUPS(N_GROUPS)) u_sig (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .cmd_i     (cmd),
        .grp_err_i (grp_err),
        .flags_o   (signature_o)
    );

    assign any_err_o = |signature_o;

    AST_ERR_NEEDS_SAMPLE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(any_err_o) |-> ($past(sample_en_i) && !$past(clear_i))); // R5

    AST_NEW_BIT_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        ((signature_o & ~$past(signature_o)) != '0) |-> $past(grp_err != '0)); // R3

endmodule

// File: tb/ica_checker_array_bench.sv
module ica_checker_array_bench;
    localparam int NS = 16;
    localparam int NI = 16;
    localparam int NG = 4;
    localparam int SC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] sites = '0;
    logic          sample_en = 1'b0;
    logic          clr = 1'b0;
    logic [NG-1:0] sig;
    logic          any_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NS-1:0] solo_pat [NG];
    logic [NS-1:0] quiet_pat;

    always #2 clk = ~clk;

    ica_checker_array #(.N_SITES(NS), .N_IMPL(NI), .N_GROUPS(NG), .SETTLE_CYC(SC)) u_ica_checker_array (
        .clk_i       (clk),
        .rst_i       (rst),
        .sites_i     (sites),
        .sample_en_i (sample_en),
        .clear_i     (clr),
        .signature_o (sig),
        .any_err_o   (any_err)
    );

    // Bench model of R1 and R2
    function automatic logic [NG-1:0] exp_groups(input logic [NS-1:0] p);
        logic [NG-1:0] e = '0;
        for (int k = 0; k < NI; k++) begin
            int a = k % NS;
            int c = (5 * k + 3) % NS;
            logic av = k[0];
            logic cv = k[1];
            if (p[a] == av && p[c] != cv) e[k % NG] = 1'b1;
        end
        return e;
    endfunction

    task automatic chk(input string req, input logic [NG-1:0] got, input logic [NG-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s signature got %b expected %b", req, got, exp);
        end
        checks++;
        if (any_err !== (|exp)) begin
            errors++;
            $display("FAIL R8 (%s) any_err got %b expected %b", req, any_err, |exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        edges(1);
        clr = 1'b0;
    endtask

    task automatic find_patterns();
        bit found [NG];
        bit qfound = 0;
        for (int g = 0; g < NG; g++) found[g] = 0;
        for (int p = 0; p < (1 << NS); p++) begin
            logic [NG-1:0] e = exp_groups(NS'(p));
            if (e == '0 && !qfound) begin quiet_pat = NS'(p); qfound = 1; end
            for (int g = 0; g < NG; g++)
                if (!found[g] && e == NG'(1 << g)) begin solo_pat[g] = NS'(p); found[g] = 1; end
        end
        for (int g = 0; g < NG; g++) begin
            checks++;
            if (!found[g]) begin errors++; $display("FAIL R3 no single-group vector got 0 expected 1 (group %0d)", g); end
        end
        checks++;
        if (!qfound) begin errors++; $display("FAIL R1 no quiet vector got 0 expected 1"); end
    endtask

    task automatic t_reset();
        rst = 1'b1; sample_en = 1'b0; clr = 1'b0; sites = '0;
        edges(3);
        rst = 1'b0;
        chk("R9 reset", sig, '0);
    endtask

    // R3 R2 R1: each group in isolation
    task automatic t_isolation();
        for (int g = 0; g < NG; g++) begin
            do_clear();
            sites = solo_pat[g]; sample_en = 1'b1;
            edges(SC + 3);
            chk("R3 single group", sig, NG'(1 << g));
            sample_en = 1'b0;
        end
    endtask

    // R4: stays set once the violation goes away
    task automatic t_sticky();
        do_clear();
        sites = solo_pat[1]; sample_en = 1'b1;
        edges(SC + 3);
        sites = quiet_pat;
        edges(SC + 6);
        chk("R4 sticky", sig, 4'b0010);
        sample_en = 1'b0;
    endtask

    // R5: no capture with sample enable low
    task automatic t_no_sample();
        do_clear();
        sample_en = 1'b0;
        sites = solo_pat[0];
        edges(SC + 8);
        chk("R5 sample off", sig, '0);
        sample_en = 1'b1;
        edges(1);
        chk("R5 sample on", sig, 4'b0001);
        sample_en = 1'b0;
    endtask

    // R6: settling window
    task automatic t_settle();
        do_clear();
        sites = quiet_pat; sample_en = 1'b1;
        edges(SC + 3);
        chk("R6 quiet", sig, '0);
        sites = solo_pat[3];
        edges(SC + 1);
        chk("R6 before settle", sig, '0);
        edges(1);
        chk("R6 at settle", sig, 4'b1000);
        do_clear();
        for (int i = 0; i < 12; i++) begin
            sites = (i % 2 == 0) ? solo_pat[2] : quiet_pat;
            edges(1);
        end
        chk("R6 toggling", sig, '0);
        sample_en = 1'b0;
    endtask

    // R7: clear wins over simultaneous qualified violation
    task automatic t_clear_priority();
        do_clear();
        sites = solo_pat[0]; sample_en = 1'b0;
        edges(SC + 3);
        sample_en = 1'b1; clr = 1'b1;
        edges(1);
        chk("R7 clear priority", sig, '0);
        clr = 1'b0;
        edges(1);
        chk("R7 capture after clear", sig, 4'b0001);
        sample_en = 1'b0;
        do_clear();
        chk("R7 clear", sig, '0);
    endtask

    // R1 R2 R3: several arbitrary vectors accumulate
    task automatic t_patterns();
        logic [NS-1:0] pats [4] = '{16'hA5C3, 16'h0F0F, 16'h1234, 16'hFFFF};
        logic [NG-1:0] acc;
        for (int i = 0; i < 4; i++) begin
            do_clear();
            sites = pats[i]; sample_en = 1'b1;
            edges(SC + 3);
            chk("R1 vector", sig, exp_groups(pats[i]));
        end
        do_clear();
        acc = '0;
        for (int i = 0; i < 2; i++) begin
            sites = pats[i];
            edges(SC + 3);
            acc |= exp_groups(pats[i]);
        end
        chk("R3 accumulate", sig, acc);
        sample_en = 1'b0;
    endtask

    initial begin
        find_patterns();
        t_reset();
        t_isolation();
        t_sticky();
        t_no_sample();
        t_settle();
        t_clear_priority();
        t_patterns();
        t_reset();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule